// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability Registers

This block keeps the configuration registers of a message-signalled-interrupt capability for a bus endpoint. Software reaches them through a simple register port: a dword index relative to the capability base, a write strobe with byte enables, and a read data bus. Three elaboration parameters fix how many vectors the function can raise, whether the message address is 64 bits wide, and whether each vector can be masked on its own. The capability length and the place of each field follow from those options.

Each field has its own write mask. The enable bit and the enabled-vector field of the control word are the only writable bits there. The two low address bits are fixed at zero. Mask bits exist only for implemented vectors. Pending bits are set and cleared by the delivery logic beside the block, and software can only read them. A write that leaves the function enabled clamps an oversized vector request to the capable count. The same write drops pending bits above the granted count and raises a one-cycle request to quiet the legacy wired interrupt. The block drives the enable flag, the granted vector count, the message address and data, and the mask and pending vectors to the delivery logic.

Top module: `msi_cap_regs`

## Requirements
- R1: Reset clears the enable bit, the enabled-vector field, both address registers, the data field, the mask and the pending bits. After reset, `vec_alloc` is 1 and `msi_en` is 0.
- R2: The control word is the upper half of dword 0, which is byte offset 0x02; the lower half reads zero. In the control word, bit 0 is the enable bit and bits 6:4 are the enabled-vector log2; only these two are writable. Bits 3:1 read the log2 of the capable vector count. Bit 7 reads 1 for 64-bit addressing, and bit 8 reads 1 when per-vector masking is present.
- R3: The low address register is dword 1. Its bits 31:2 are writable and its bits 1:0 always read zero.
- R4: In the 64-bit variant, dword 2 is the upper address register and is fully writable. `msg_addr` is the upper register and the low register joined. In the 32-bit variant, `msg_addr[63:32]` is zero.
- R5: The 16-bit message data field is the low half of dword 3 in the 64-bit variant and of dword 2 in the 32-bit variant. It is fully writable, and the upper half of its dword reads zero.
- R6: With masking, the mask register is dword 4 in the 64-bit variant or dword 3 in the 32-bit variant. Only bits 0 to N-1 are writable, where N is the capable count.
- R7: With masking, the pending register is dword 5 in the 64-bit variant or dword 4 in the 32-bit variant. Register writes do not change it. `pend_set` sets bits below N, and `pend_clr` clears bits; when both act on the same bit in the same cycle, the clear wins.
- R8: A write that leaves the enable bit set with the enabled-vector field above the capable log2 stores the capable log2 instead. While the enable bit is clear, the field keeps the value written. `vec_alloc` equals 2 raised to the field.
- R9: A write that leaves the enable bit set drops every pending bit at or above the granted count. A write made while disabled leaves the pending bits unchanged.
- R10: `intx_deassert` is high for exactly the cycle after a write that leaves the enable bit set. It stays low otherwise.
- R11: Reads of dwords at or beyond the capability length return zero, and writes to them change nothing. The length is 0x0A, 0x0E, 0x14 or 0x18 bytes for 32-bit, 64-bit, 32-bit masked and 64-bit masked.
- R12: A write changes only the bytes whose enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 6 | Dword index from the capability base (byte offset / 4) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables for the write |
| rd_data | output | 32 | Read data of the dword at reg_idx |
| pend_set | input | 32 | Delivery logic: mark vectors pending |
| pend_clr | input | 32 | Delivery logic: clear pending vectors |
| msi_en | output | 1 | Message interrupts enabled |
| vec_alloc | output | 8 | Number of vectors granted by software |
| msg_addr | output | 64 | Message address |
| msg_data | output | 16 | Message data |
| vec_mask | output | 32 | Per-vector mask bits |
| vec_pend | output | 32 | Per-vector pending bits |
| intx_deassert | output | 1 | One-cycle request to drop the legacy wired interrupt |

## Verification
`rd_data` is combinational on the stored registers, so a read is due in the same cycle its index is presented. A write, a set or clear of pending bits, and the clamp all land on the clock edge that samples the strobe. Those results, and the `intx_deassert` pulse, are therefore due half a cycle after that edge and are gone one cycle later. The bench drives every input on the falling edge. It samples outputs on the next falling edge, and it samples the pulse once more a full cycle later to confirm it has ended.

// File: rtl/msi_cap_pkg.sv
`timescale 1ns/1ps
package msi_cap_pkg;

    localparam int MAX_VEC = 32;

    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_CTRL,
        FLD_ALO,
        FLD_AHI,
        FLD_DATA,
        FLD_MASK,
        FLD_PEND
    } fld_e;

    typedef struct packed {
        logic                en;
        logic [2:0]          mme;
        logic [29:0]         alo;
        logic [31:0]         ahi;
        logic [15:0]         data;
        logic [MAX_VEC-1:0]  mask;
        logic [MAX_VEC-1:0]  pend;
        logic                intx;
    } regs_t;

    // Which field lives in a given dword for a given variant.
    function automatic fld_e field_of(input logic [5:0] dw, input bit a64, input bit pvm);
        fld_e f;
        case (dw)
            6'd0:    f = FLD_CTRL;
            6'd1:    f = FLD_ALO;
            6'd2:    f = a64 ? FLD_AHI : FLD_DATA;
            6'd3:    f = a64 ? FLD_DATA : (pvm ? FLD_MASK : FLD_NONE);
            6'd4:    f = pvm ? (a64 ? FLD_MASK : FLD_PEND) : FLD_NONE;
            6'd5:    f = (pvm && a64) ? FLD_PEND : FLD_NONE;
            default: f = FLD_NONE;
        endcase
        return f;
    endfunction

    // Bitmask of the first 2**lg vectors.
    function automatic logic [MAX_VEC-1:0] lowmask(input logic [2:0] lg);
        logic [MAX_VEC-1:0] m;
        if (lg >= 3'd5) m = '1;
        else            m = (32'd1 << (6'd1 << lg)) - 32'd1;
        return m;
    endfunction

    function automatic int cap_bytes(input bit a64, input bit pvm);
        int n;
        if (pvm) n = a64 ? 24 : 20;
        else     n = a64 ? 14 : 10;
        return n;
    endfunction

endpackage

// File: rtl/msi_cap_decode.sv
`timescale 1ns/1ps
module msi_cap_decode
    import msi_cap_pkg::*;
#(
    parameter int ADDR64 = 1,
    parameter int PVM    = 1
) (
    input  logic [5:0] idx,
    output fld_e       fld
);
    localparam bit A64 = (ADDR64 != 0);
    localparam bit MSK = (PVM != 0);

    assign fld = field_of(idx, A64, MSK);
endmodule

// File: rtl/msi_cap_merge.sv
`timescale 1ns/1ps
module msi_cap_merge #(
    parameter int NB = 4
) (
    input  logic [8*NB-1:0] old_v,
    input  logic [8*NB-1:0] new_v,
    input  logic [8*NB-1:0] wmask,
    input  logic [NB-1:0]   be,
    output logic [8*NB-1:0] merged
);
    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign merged[8*b +: 8] = be[b]
            ? ((new_v[8*b +: 8] & wmask[8*b +: 8]) | (old_v[8*b +: 8] & ~wmask[8*b +: 8]))
            : old_v[8*b +: 8];
    end
endmodule

// File: rtl/msi_cap_regs.sv
`timescale 1ns/1ps
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter int VEC_LOG2 = 2,
    parameter int ADDR64   = 1,
    parameter int PVM      = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  reg_idx,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic [3:0]  wr_be,
    output logic [31:0] rd_data,
    input  logic [31:0] pend_set,
    input  logic [31:0] pend_clr,
    output logic        msi_en,
    output logic [7:0]  vec_alloc,
    output logic [63:0] msg_addr,
    output logic [15:0] msg_data,
    output logic [31:0] vec_mask,
    output logic [31:0] vec_pend,
    output logic        intx_deassert
);
    localparam logic [2:0]         CAP_LG  = 3'(VEC_LOG2);
    localparam logic [MAX_VEC-1:0] IMPL    = lowmask(CAP_LG);
    localparam logic               A64_BIT = (ADDR64 != 0);
    localparam logic               PVM_BIT = (PVM != 0);
    localparam logic [31:0]        WM_CTRL = 32'h0071_0000;
    localparam logic [31:0]        WM_ALO  = 32'hFFFF_FFFC;
    localparam logic [31:0]        WM_AHI  = 32'hFFFF_FFFF;
    localparam logic [31:0]        WM_DATA = 32'h0000_FFFF;

    regs_t r_d, r_q;
    fld_e  fld;
    logic [31:0] view;
    logic [31:0] wmask;
    logic [31:0] merged;
    logic [15:0] ctrl_word;
    logic [31:0] pend_v;

    msi_cap_decode #(.ADDR64(ADDR64), .PVM(PVM)) u_dec (
        .idx (reg_idx),
        .fld (fld)
    );

    assign ctrl_word = {7'd0, PVM_BIT, A64_BIT, r_q.mme, CAP_LG, r_q.en};

    // Read view and write mask of the addressed dword.
    always_comb begin
        view  = '0;
        wmask = '0;
        case (fld)
            FLD_CTRL: begin view = {ctrl_word, 16'h0000}; wmask = WM_CTRL; end
            FLD_ALO:  begin view = {r_q.alo, 2'b00};      wmask = WM_ALO;  end
            FLD_AHI:  begin view = r_q.ahi;               wmask = WM_AHI;  end
            FLD_DATA: begin view = {16'h0000, r_q.data};  wmask = WM_DATA; end
            FLD_MASK: begin view = r_q.mask;              wmask = IMPL;    end
            FLD_PEND: begin view = r_q.pend;              wmask = '0;      end
            default:  begin view = '0;                    wmask = '0;      end
        endcase
    end

    msi_cap_merge #(.NB(4)) u_merge (
        .old_v  (view),
        .new_v  (wr_data),
        .wmask  (wmask),
        .be     (wr_be),
        .merged (merged)
    );

    // Next-state computation.
    always_comb begin
        r_d      = r_q;
        r_d.intx = 1'b0;
        pend_v   = (r_q.pend | (pend_set & IMPL)) & ~pend_clr;
        r_d.pend = PVM_BIT ? pend_v : '0;
        if (wr_en) begin
            case (fld)
                FLD_CTRL: begin
                    r_d.en  = merged[16];
                    r_d.mme = merged[22:20];
                end
                FLD_ALO:  r_d.alo  = merged[31:2];
                FLD_AHI:  r_d.ahi  = merged;
                FLD_DATA: r_d.data = merged[15:0];
                FLD_MASK: r_d.mask = merged;
                default:  ;
            endcase
            if (r_d.en && (r_d.mme > CAP_LG)) begin
                r_d.mme = CAP_LG;
            end
            if (r_d.en) begin
                r_d.intx = 1'b1;
                r_d.pend = r_d.pend & lowmask(r_d.mme);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data       = view;
    assign msi_en        = r_q.en;
    assign vec_alloc     = 8'd1 << r_q.mme;
    assign msg_addr      = {(A64_BIT ? r_q.ahi : 32'h0), r_q.alo, 2'b00};
    assign msg_data      = r_q.data;
    assign vec_mask      = r_q.mask;
    assign vec_pend      = r_q.pend;
    assign intx_deassert = r_q.intx;
endmodule

// File: rtl/msi_cap_chk.sv
`timescale 1ns/1ps
module msi_cap_chk
    import msi_cap_pkg::*;
#(
    parameter int VEC_LOG2 = 2,
    parameter int ADDR64   = 1,
    parameter int PVM      = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  reg_idx,
    input logic        wr_en,
    input logic [31:0] rd_data,
    input logic        msi_en,
    input logic [7:0]  vec_alloc,
    input logic [63:0] msg_addr,
    input logic [15:0] msg_data,
    input logic [31:0] vec_mask,
    input logic [31:0] vec_pend,
    input logic        intx_deassert
);
    localparam int                 NVEC = 1 << VEC_LOG2;
    localparam logic [MAX_VEC-1:0] IMPL = lowmask(3'(VEC_LOG2));
    localparam int                 LEN  = cap_bytes(ADDR64 != 0, PVM != 0);

    assert_alo_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_addr[1:0] == 2'b00);

    assert_mask_impl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_mask & ~IMPL) == '0);

    assert_pend_impl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_pend & ~IMPL) == '0);

    assert_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msi_en |-> (int'(vec_alloc) <= NVEC));

    assert_intx_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        intx_deassert |-> msi_en);

    assert_intx_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !intx_deassert);

    assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(msg_data));

    assert_hole_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_idx) * 4 >= LEN) |-> (rd_data == 32'h0));
endmodule

bind msi_cap_regs msi_cap_chk #(
    .VEC_LOG2 (VEC_LOG2),
    .ADDR64   (ADDR64),
    .PVM      (PVM)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_idx       (reg_idx),
    .wr_en         (wr_en),
    .rd_data       (rd_data),
    .msi_en        (msi_en),
    .vec_alloc     (vec_alloc),
    .msg_addr      (msg_addr),
    .msg_data      (msg_data),
    .vec_mask      (vec_mask),
    .vec_pend      (vec_pend),
    .intx_deassert (intx_deassert)
);

// File: tb/msi_cap_regs_test.sv
`timescale 1ns/1ps
module msi_cap_regs_test;

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] wd;
        logic [3:0]  be;
        logic [31:0] exp;
    } vec_t;

    // Default variant: 4 vectors, 64-bit address, per-vector masking.
    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{6'd1, 32'hFFFF_FFFF, 4'hF, 32'hFFFF_FFFC},  // R3
        '{6'd2, 32'h1234_5678, 4'hF, 32'h1234_5678},  // R4
        '{6'd3, 32'hABCD_1234, 4'hF, 32'h0000_1234},  // R5
        '{6'd4, 32'hFFFF_FFFF, 4'hF, 32'h0000_000F},  // R6
        '{6'd5, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000},  // R7
        '{6'd1, 32'h0000_0000, 4'h2, 32'hFFFF_00FC},  // R12
        '{6'd6, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000},  // R11
        '{6'd0, 32'hFFFF_FFFF, 4'hF, 32'h01A5_0000},  // R8
        '{6'd0, 32'hFFFF_FFFF, 4'h3, 32'h01A5_0000},  // R12
        '{6'd0, 32'h0070_0000, 4'hF, 32'h01F4_0000}   // R8
    };

    function automatic string tag_of(input int i);
        string s;
        case (i)
            0: s = "R3";  1: s = "R4";  2: s = "R5";  3: s = "R6";
            4: s = "R7";  5: s = "R12"; 6: s = "R11"; 7: s = "R8";
            8: s = "R12"; default: s = "R8";
        endcase
        return s;
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_idx = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] rd_data;
    logic [31:0] pend_set = '0;
    logic [31:0] pend_clr = '0;
    logic        msi_en;
    logic [7:0]  vec_alloc;
    logic [63:0] msg_addr;
    logic [15:0] msg_data;
    logic [31:0] vec_mask;
    logic [31:0] vec_pend;
    logic        intx_deassert;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    msi_cap_regs uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_idx       (reg_idx),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .wr_be         (wr_be),
        .rd_data       (rd_data),
        .pend_set      (pend_set),
        .pend_clr      (pend_clr),
        .msi_en        (msi_en),
        .vec_alloc     (vec_alloc),
        .msg_addr      (msg_addr),
        .msg_data      (msg_data),
        .vec_mask      (vec_mask),
        .vec_pend      (vec_pend),
        .intx_deassert (intx_deassert)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] i, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        reg_idx = i; wr_data = d; wr_be = b; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] i, input logic [31:0] exp);
        reg_idx = i;
        #0.5;
        chk(req, {32'h0, rd_data}, {32'h0, exp});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_reset_state();
        rd_chk("R2", 6'd0, 32'h0184_0000);
        for (int i = 1; i < 6; i++) rd_chk("R1", 6'(i), 32'h0);
        chk("R1", {63'h0, msi_en}, 64'h0);
        chk("R1", {56'h0, vec_alloc}, 64'd1);
        chk("R1", msg_addr, 64'h0);
        chk("R1", {48'h0, msg_data}, 64'h0);
        chk("R1", {32'h0, vec_mask}, 64'h0);
        chk("R1", {32'h0, vec_pend}, 64'h0);
        chk("R1", {63'h0, intx_deassert}, 64'h0);
    endtask

    initial begin
        do_reset();
        check_reset_state();

        // Table walk: write, then read the same dword back.
        for (int i = 0; i < NV; i++) begin
            wr(TBL[i].idx, TBL[i].wd, TBL[i].be);
            rd_chk(tag_of(i), TBL[i].idx, TBL[i].exp);
        end

        // R8: disabled, oversized request is kept as written.
        chk("R8", {63'h0, msi_en}, 64'h0);
        chk("R8", {56'h0, vec_alloc}, 64'd128);
        chk("R4", msg_addr, 64'h1234_5678_FFFF_00FC);
        chk("R5", {48'h0, msg_data}, 64'h1234);
        chk("R6", {32'h0, vec_mask}, 64'hF);

        // R7: set beyond N ignored, clear acts.
        @(negedge clk); pend_set = 32'hFF;
        @(negedge clk); pend_set = '0;
        chk("R7", {32'h0, vec_pend}, 64'h0F);
        pend_clr = 32'h1;
        @(negedge clk); pend_clr = '0;
        chk("R7", {32'h0, vec_pend}, 64'h0E);
        rd_chk("R7", 6'd5, 32'h0E);

        // R7: clear wins over set on the same bit.
        pend_set = 32'h1; pend_clr = 32'h1;
        @(negedge clk); pend_set = '0; pend_clr = '0;
        chk("R7", {32'h0, vec_pend}, 64'h0E);

        // R9/R10: write while disabled.
        wr(6'd3, 32'h0000_5555, 4'hF);
        chk("R10", {63'h0, intx_deassert}, 64'h0);
        chk("R9", {32'h0, vec_pend}, 64'h0E);

        // R8/R9/R10: enable with two vectors granted.
        wr(6'd0, 32'h0011_0000, 4'hF);
        chk("R10", {63'h0, intx_deassert}, 64'h1);
        chk("R8", {63'h0, msi_en}, 64'h1);
        chk("R8", {56'h0, vec_alloc}, 64'd2);
        chk("R9", {32'h0, vec_pend}, 64'h02);
        @(negedge clk);
        chk("R10", {63'h0, intx_deassert}, 64'h0);
        chk("R5", {48'h0, msg_data}, 64'h5555);

        // R1: reset mid-run.
        do_reset();
        check_reset_state();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule